// File: doc/BRIEF.md
# Fixed-Point Interval Multiplier

This block multiplies two closed intervals of signed fixed-point numbers and returns an interval in a second fixed-point format that is guaranteed to contain every product of a point in the first interval and a point in the second. All four corner products are formed at once. Each product is rounded two ways: down toward negative infinity for the lower-bound candidates and up toward positive infinity for the upper-bound candidates. A comparator tree then takes the minimum of the downward copies and the maximum of the upward copies. The rounding directions are set by the wiring of each path. There is no rounding-mode input.

A square input makes the block compute the range of x² for x in the A interval and ignore the B operands. This removes the spurious negative bound that a general product of an interval with itself gives when the interval contains zero. Operands enter through a valid/ready handshake and the result is registered, so one interval can be accepted every cycle.

The control is a three-state machine. `ST_EMPTY` holds no result. `ST_RESULT` presents a result with `out_valid` high. `ST_FAULT` pulses `err_o` for one cycle after a malformed operand. In `ST_EMPTY` or `ST_FAULT`, an accepted good operand moves the machine to `ST_RESULT`, an accepted malformed operand moves it to `ST_FAULT`, and no input moves it to `ST_EMPTY`. `ST_RESULT` stays where it is while `out_ready` is low. Once `out_ready` is high it takes the same three transitions.

Top module: `fxiv_mul`

## Requirements
- R1: In general mode, `lo_o` is the minimum and `hi_o` the maximum over the four products a_lo·b_lo, a_lo·b_hi, a_hi·b_lo and a_hi·b_hi. Inputs are two's complement with IN_FRAC fraction bits and outputs are two's complement with OUT_FRAC fraction bits (defaults 8-bit inputs, 10-bit outputs, 2 fraction bits each).
- R2: Every product is rounded before the min/max selection. The lower-bound copy is rounded toward negative infinity (floor at OUT_FRAC) and the upper-bound copy toward positive infinity (ceiling). Exact products pass through unchanged.
- R3: A lower bound outside the output range becomes the most negative output code. An upper bound outside the range becomes the most positive code.
- R4: In square mode, when a_lo ≤ 0 ≤ a_hi, `lo_o` is 0 and `hi_o` is the larger of a_lo² and a_hi², rounded up. For X=[-2,3] this gives [0,9], whereas general mode on the same operands gives [-6,9].
- R5: In square mode with an interval entirely on one side of zero, the bounds are the two endpoint squares in order, lower rounded down and upper rounded up. The B operands have no effect.
- R6: An accepted operand with a_lo > a_hi, or in general mode with b_lo > b_hi, raises `err_o` for exactly one cycle and produces no `out_valid`.
- R7: A result appears with `out_valid` one cycle after acceptance. While `out_ready` is low it stays stable and `in_ready` is low.
- R8: With `out_ready` held high, operands presented on consecutive cycles yield results on consecutive cycles.
- R9: After reset, `out_valid` and `err_o` are 0 and `in_ready` is 1.
- R10: Every valid output satisfies `lo_o` ≤ `hi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand interval present |
| in_ready | output | 1 | Block can accept operands |
| sq_mode | input | 1 | 1: square the A interval and ignore B |
| a_lo | input | IN_W | Lower bound of A |
| a_hi | input | IN_W | Upper bound of A |
| b_lo | input | IN_W | Lower bound of B |
| b_hi | input | IN_W | Upper bound of B |
| out_valid | output | 1 | Result interval present |
| out_ready | input | 1 | Consumer takes the result |
| lo_o | output | OUT_W | Result lower bound |
| hi_o | output | OUT_W | Result upper bound |
| err_o | output | 1 | One-cycle pulse for a malformed operand |

## Verification
The ordering assertion on every valid result relies on the consumer handshake and the malformed-operand screen: only operands that pass the screen ever reach the result register. The hold assertion assumes that `out_ready` is the only thing that releases a result. The square-mode assertion assumes that saturation of the upper bound only ever moves it to the positive limit. The stimulus changes inputs on the falling edge and keeps them until an accepting rising edge. It uses values small enough for exact integer reference products and sends malformed operands only through the dedicated fault scenario.

// File: rtl/fxiv_pkg.sv
package fxiv_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } fxiv_state_e;

    localparam int NCORNER = 4;

endpackage

// File: rtl/fxiv_corner.sv
module fxiv_corner #(
    parameter int IN_W     = 8,
    parameter int IN_FRAC  = 2,
    parameter int OUT_FRAC = 2
) (
    input  logic signed [IN_W-1:0]   x_i,
    input  logic signed [IN_W-1:0]   y_i,
    output logic signed [2*IN_W-1:0] dn_o,
    output logic signed [2*IN_W-1:0] up_o
);
    localparam int PW = 2 * IN_W;
    localparam int SH = 2 * IN_FRAC - OUT_FRAC;

    logic signed [PW-1:0] xe, ye, prod, floor_v;
    logic                 rem_nz;

    assign xe   = PW'(x_i);
    assign ye   = PW'(y_i);
    assign prod = xe * ye;

    generate
        if (SH == 0) begin : g_noshift
            assign floor_v = prod;
            assign rem_nz  = 1'b0;
        end else begin : g_shift
            assign floor_v = prod >>> SH;
            assign rem_nz  = |prod[SH-1:0];
        end
    endgenerate

    // toward negative infinity: arithmetic shift drops bits downward
    assign dn_o = floor_v;
    // toward positive infinity: bump when any dropped bit was set
    assign up_o = floor_v + PW'(rem_nz);

endmodule

// File: rtl/fxiv_reduce.sv
module fxiv_reduce #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] dn_i [fxiv_pkg::NCORNER],
    input  logic signed [W-1:0] up_i [fxiv_pkg::NCORNER],
    output logic signed [W-1:0] lo_o,
    output logic signed [W-1:0] hi_o
);
    localparam int HALF = fxiv_pkg::NCORNER / 2;

    logic signed [W-1:0] mn1 [HALF];
    logic signed [W-1:0] mx1 [HALF];

    generate
        for (genvar i = 0; i < HALF; i++) begin : g_lvl1
            assign mn1[i] = (dn_i[2*i] < dn_i[2*i+1]) ? dn_i[2*i] : dn_i[2*i+1];
            assign mx1[i] = (up_i[2*i] > up_i[2*i+1]) ? up_i[2*i] : up_i[2*i+1];
        end
    endgenerate

    assign lo_o = (mn1[0] < mn1[1]) ? mn1[0] : mn1[1];
    assign hi_o = (mx1[0] > mx1[1]) ? mx1[0] : mx1[1];

endmodule

// File: rtl/fxiv_square.sv
module fxiv_square #(
    parameter int IN_W = 8,
    parameter int W    = 16
) (
    input  logic signed [IN_W-1:0] a_lo_i,
    input  logic signed [IN_W-1:0] a_hi_i,
    input  logic signed [W-1:0]    ll_dn_i,
    input  logic signed [W-1:0]    ll_up_i,
    input  logic signed [W-1:0]    hh_dn_i,
    input  logic signed [W-1:0]    hh_up_i,
    output logic signed [W-1:0]    lo_o,
    output logic signed [W-1:0]    hi_o
);
    logic straddle, all_pos;

    assign straddle = (a_lo_i <= 0) && (a_hi_i >= 0);
    assign all_pos  = (a_lo_i > 0);

    always_comb begin
        if (straddle) begin
            lo_o = '0;
            hi_o = (ll_up_i > hh_up_i) ? ll_up_i : hh_up_i;
        end else if (all_pos) begin
            lo_o = ll_dn_i;
            hi_o = hh_up_i;
        end else begin
            lo_o = hh_dn_i;
            hi_o = ll_up_i;
        end
    end

endmodule

// File: rtl/fxiv_sat.sv
module fxiv_sat #(
    parameter int W     = 16,
    parameter int OUT_W = 10,
    parameter bit UP    = 1'b0
) (
    input  logic signed [W-1:0]     v_i,
    output logic signed [OUT_W-1:0] q_o
);
    localparam logic signed [W-1:0] QMAX = {{(W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [W-1:0] QMIN = {{(W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic ovf;
    assign ovf = (v_i > QMAX) || (v_i < QMIN);

    generate
        if (UP) begin : g_up
            assign q_o = ovf ? QMAX[OUT_W-1:0] : v_i[OUT_W-1:0];
        end else begin : g_dn
            assign q_o = ovf ? QMIN[OUT_W-1:0] : v_i[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/fxiv_mul.sv
module fxiv_mul
    import fxiv_pkg::*;
#(
    parameter int IN_W     = 8,
    parameter int IN_FRAC  = 2,
    parameter int OUT_W    = 10,
    parameter int OUT_FRAC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    sq_mode,
    input  logic signed [IN_W-1:0]  a_lo,
    input  logic signed [IN_W-1:0]  a_hi,
    input  logic signed [IN_W-1:0]  b_lo,
    input  logic signed [IN_W-1:0]  b_hi,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] lo_o,
    output logic signed [OUT_W-1:0] hi_o,
    output logic                    err_o
);
    localparam int PW = 2 * IN_W;

    fxiv_state_e st_q, st_nx;

    logic signed [IN_W-1:0] opx [NCORNER];
    logic signed [IN_W-1:0] opy [NCORNER];
    logic signed [PW-1:0]   c_dn [NCORNER];
    logic signed [PW-1:0]   c_up [NCORNER];
    logic signed [PW-1:0]   gen_lo, gen_hi, sq_lo, sq_hi, pre_lo, pre_hi;
    logic signed [PW-1:0]   pre [2];
    logic signed [OUT_W-1:0] sat_q [2];
    logic signed [OUT_W-1:0] lo_q, hi_q;
    logic                   bad, accept;

    // operand routing: square mode feeds A into the B side
    always_comb begin
        opx[0] = a_lo;
        opx[1] = a_lo;
        opx[2] = a_hi;
        opx[3] = a_hi;
        opy[0] = sq_mode ? a_lo : b_lo;
        opy[1] = sq_mode ? a_hi : b_hi;
        opy[2] = sq_mode ? a_lo : b_lo;
        opy[3] = sq_mode ? a_hi : b_hi;
    end

    generate
        for (genvar i = 0; i < NCORNER; i++) begin : g_corner
            fxiv_corner #(
                .IN_W    (IN_W),
                .IN_FRAC (IN_FRAC),
                .OUT_FRAC(OUT_FRAC)
            ) u_corner (
                .x_i (opx[i]),
                .y_i (opy[i]),
                .dn_o(c_dn[i]),
                .up_o(c_up[i])
            );
        end
    endgenerate

    fxiv_reduce #(.W(PW)) u_reduce (
        .dn_i(c_dn),
        .up_i(c_up),
        .lo_o(gen_lo),
        .hi_o(gen_hi)
    );

    fxiv_square #(.IN_W(IN_W), .W(PW)) u_square (
        .a_lo_i (a_lo),
        .a_hi_i (a_hi),
        .ll_dn_i(c_dn[0]),
        .ll_up_i(c_up[0]),
        .hh_dn_i(c_dn[3]),
        .hh_up_i(c_up[3]),
        .lo_o   (sq_lo),
        .hi_o   (sq_hi)
    );

    assign pre_lo = sq_mode ? sq_lo : gen_lo;
    assign pre_hi = sq_mode ? sq_hi : gen_hi;
    assign pre[0] = pre_lo;
    assign pre[1] = pre_hi;

    generate
        for (genvar d = 0; d < 2; d++) begin : g_sat
            fxiv_sat #(.W(PW), .OUT_W(OUT_W), .UP(d == 1)) u_sat (
                .v_i(pre[d]),
                .q_o(sat_q[d])
            );
        end
    endgenerate

    assign bad      = (a_lo > a_hi) || (!sq_mode && (b_lo > b_hi));
    assign in_ready = (st_q != ST_RESULT) || out_ready;
    assign accept   = in_valid && in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_EMPTY, ST_FAULT: begin
                if (in_valid) st_nx = bad ? ST_FAULT : ST_RESULT;
                else          st_nx = ST_EMPTY;
            end
            ST_RESULT: begin
                if (out_ready) begin
                    if (in_valid) st_nx = bad ? ST_FAULT : ST_RESULT;
                    else          st_nx = ST_EMPTY;
                end
            end
            default: st_nx = ST_EMPTY;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (accept && !bad) begin
            lo_q <= sat_q[0];
            hi_q <= sat_q[1];
        end
    end

    assign lo_o      = lo_q;
    assign hi_o      = hi_q;
    assign out_valid = (st_q == ST_RESULT);
    assign err_o     = (st_q == ST_FAULT);

    AST_LO_LE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lo_o <= hi_o)); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(lo_o) && $stable(hi_o))); // R7
    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !bad) |=> out_valid); // R8
    AST_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && bad) |=> (err_o && !out_valid)); // R6
    AST_SQ_HI_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !bad && sq_mode) |=> (hi_o >= 0)); // R4

endmodule

// File: tb/fxiv_mul_tb.sv
module fxiv_mul_tb;
    localparam int IN_W = 8;
    localparam int OUT_W = 10;
    localparam int SH = 2;
    localparam int QMAX = 511;
    localparam int QMIN = -512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic sq_mode = 1'b0;
    logic signed [IN_W-1:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic signed [OUT_W-1:0] lo_o, hi_o;
    logic err_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fxiv_mul u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .sq_mode(sq_mode), .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
        .out_valid(out_valid), .out_ready(out_ready), .lo_o(lo_o), .hi_o(hi_o),
        .err_o(err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rdn(input int p);
        return p >>> SH;
    endfunction
    function automatic int rup(input int p);
        return -((-p) >>> SH);
    endfunction
    function automatic int slo(input int v);
        return (v > QMAX || v < QMIN) ? QMIN : v;
    endfunction
    function automatic int shi(input int v);
        return (v > QMAX || v < QMIN) ? QMAX : v;
    endfunction

    function automatic void model_gen(input int al, ah, bl, bh, output int lo, hi);
        int p [4];
        p[0] = al * bl; p[1] = al * bh; p[2] = ah * bl; p[3] = ah * bh;
        lo = rdn(p[0]); hi = rup(p[0]);
        for (int i = 1; i < 4; i++) begin
            if (rdn(p[i]) < lo) lo = rdn(p[i]);
            if (rup(p[i]) > hi) hi = rup(p[i]);
        end
        lo = slo(lo); hi = shi(hi);
    endfunction

    function automatic void model_sq(input int al, ah, output int lo, hi);
        if (al <= 0 && ah >= 0) begin
            lo = 0;
            hi = (rup(al*al) > rup(ah*ah)) ? rup(al*al) : rup(ah*ah);
        end else if (al > 0) begin
            lo = rdn(al*al); hi = rup(ah*ah);
        end else begin
            lo = rdn(ah*ah); hi = rup(al*al);
        end
        lo = slo(lo); hi = shi(hi);
    endfunction

    task automatic drive(input int al, ah, bl, bh, input bit sq);
        in_valid = 1'b1; sq_mode = sq;
        a_lo = IN_W'(al); a_hi = IN_W'(ah); b_lo = IN_W'(bl); b_hi = IN_W'(bh);
    endtask

    task automatic one(input string req, input int al, ah, bl, bh, input bit sq);
        int elo, ehi;
        if (sq) model_sq(al, ah, elo, ehi);
        else    model_gen(al, ah, bl, bh, elo, ehi);
        @(negedge clk);
        drive(al, ah, bl, bh, sq);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " lo"}, int'(lo_o), elo);
        chk({req, " hi"}, int'(hi_o), ehi);
    endtask

    task automatic t_reset();
        chk("R9 out_valid", int'(out_valid), 0);
        chk("R9 err_o", int'(err_o), 0);
        chk("R9 in_ready", int'(in_ready), 1);
    endtask

    task automatic t_general();
        one("R1 positive quadrant", 4, 8, 12, 20, 1'b0);
        one("R1 straddle X*X", -8, 12, -8, 12, 1'b0);
        chk("R1 X*X lo -6", int'(lo_o), -24);
        one("R1 mixed signs", -20, -4, 3, 17, 1'b0);
        one("R10 both straddle", -13, 7, -5, 9, 1'b0);
    endtask

    task automatic t_round();
        one("R2 positive inexact", 1, 1, 1, 3, 1'b0);
        chk("R2 lo floor", int'(lo_o), 0);
        chk("R2 hi ceil", int'(hi_o), 1);
        one("R2 negative inexact", -1, -1, 1, 2, 1'b0);
        chk("R2 neg lo floor", int'(lo_o), -1);
        chk("R2 neg hi ceil", int'(hi_o), 0);
        one("R2 odd corners", -3, 5, -7, 3, 1'b0);
    endtask

    task automatic t_sat();
        one("R3 both over", 80, 120, 80, 120, 1'b0);
        chk("R3 lo min", int'(lo_o), QMIN);
        chk("R3 hi max", int'(hi_o), QMAX);
        one("R3 hi only over", -4, 120, 1, 120, 1'b0);
    endtask

    task automatic t_square();
        one("R4 square X", -8, 12, 99, -99, 1'b1);
        chk("R4 sq lo 0", int'(lo_o), 0);
        chk("R4 sq hi 9", int'(hi_o), 36);
        one("R5 square negative", -12, -5, 0, 0, 1'b1);
        one("R5 square positive", 5, 7, -100, 100, 1'b1);
        one("R5 square exact", 5, 7, 3, 3, 1'b1);
    endtask

    task automatic t_malformed();
        @(negedge clk);
        drive(8, 4, 0, 1, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 a reversed err", int'(err_o), 1);
        chk("R6 a reversed no valid", int'(out_valid), 0);
        @(negedge clk);
        chk("R6 err one cycle", int'(err_o), 0);
        chk("R6 still no valid", int'(out_valid), 0);
        drive(1, 2, 5, 3, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 b reversed err", int'(err_o), 1);
        drive(1, 2, 5, 3, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 sq ignores b order", int'(err_o), 0);
        chk("R6 sq valid", int'(out_valid), 1);
    endtask

    task automatic t_backpressure();
        int elo, ehi, flo, fhi;
        model_gen(4, 8, 4, 8, elo, ehi);
        model_gen(-8, 4, 2, 6, flo, fhi);
        @(negedge clk);
        out_ready = 1'b0;
        drive(4, 8, 4, 8, 1'b0);
        @(negedge clk);
        drive(-8, 4, 2, 6, 1'b0);
        chk("R7 valid", int'(out_valid), 1);
        chk("R7 in_ready low", int'(in_ready), 0);
        @(negedge clk);
        chk("R7 held lo", int'(lo_o), elo);
        chk("R7 held hi", int'(hi_o), ehi);
        chk("R7 held valid", int'(out_valid), 1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 next lo", int'(lo_o), flo);
        chk("R7 next hi", int'(hi_o), fhi);
    endtask

    task automatic t_throughput();
        int elo, ehi, flo, fhi;
        model_gen(2, 6, -3, 9, elo, ehi);
        model_sq(-5, 3, flo, fhi);
        @(negedge clk);
        drive(2, 6, -3, 9, 1'b0);
        @(negedge clk);
        drive(-5, 3, 0, 0, 1'b1);
        chk("R8 first lo", int'(lo_o), elo);
        chk("R8 first hi", int'(hi_o), ehi);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 second valid", int'(out_valid), 1);
        chk("R8 second lo", int'(lo_o), flo);
        chk("R8 second hi", int'(hi_o), fhi);
        @(negedge clk);
        chk("R8 drained", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_general();
        t_round();
        t_sat();
        t_square();
        t_malformed();
        t_backpressure();
        t_throughput();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule